// File: doc/BRIEF.md
# Synchronous Read Slave Port with Sequential Prefetch

This block is the device side of a synchronous host bus that serves single read accesses. The host raises a select strobe. On that clock edge the port samples the word address, a 4-bit target identifier, the read strobe, the per-byte write enables and the burst flag. A cycle whose identifier differs from the strapped value is ignored entirely. A matching single read is decoded into either the memory space or the register space. The data is returned together with an active-low transfer acknowledge that lasts one cycle. The acknowledge and the data bus are modelled as tri-state pins: each has a value output and a separate drive-enable output.

When the prefetch enable is set, a memory-space read that misses also loads the next four consecutive memory words into a small read buffer. A later read of the next expected address is then answered after a single wait cycle instead of four. Register reads, matched cycles that are not single reads, and disabling prefetch all empty the buffer.

The controller has three states. In IDLE (`ST_IDLE`) nothing is driven. In WAIT (`ST_WAIT`) the latency is counted down. In ACK (`ST_ACK`) the acknowledge is low and the data bus is driven. The transitions are:
- capture: IDLE to WAIT, or ACK to WAIT, on a select with a matching single read.
- done: WAIT to ACK when the wait counter reaches zero.
- release: ACK to IDLE when no new access is presented.
- ignore: IDLE stays in IDLE on a foreign cycle or on a non-read cycle.
- hold: WAIT stays in WAIT while the counter is above zero.

A park flag keeps the acknowledge driven high for the one cycle that follows ACK.

Top module: `sync_rd_slave`

## Requirements
- R1: The address, identifier, read strobe, byte write enables and burst flag are sampled on the first rising edge with `sel` high, in IDLE or in ACK. Later changes to these inputs do not affect the access in progress.
- R2: A cycle whose `id_in` differs from `strap_id` is ignored. No acknowledge or data is driven for it, and the prefetch buffer keeps its contents.
- R3: A single read is `rd_en`=1 with `wr_be`=0 and `burst`=0. A cycle with a matching identifier that is not a single read gets no acknowledge and empties the prefetch buffer.
- R4: `addr[AW-1]`=1 selects the register space. A register word is `strap_id` in bits [DW-1:DW-4], `addr` in bits [AW-1:0], and zeros elsewhere. A memory word at address a is {a, a ^ 16'h5A3C}. A register read never hits the buffer and empties it.
- R5: The acknowledge `ack_n` is low, with `ack_oe`=1, for exactly one cycle. In the next cycle it is driven high. After that `ack_oe` falls, unless a new access is already in its own acknowledge cycle.
- R6: Counted from the capture edge, the acknowledge cycle follows 4 wait cycles on a memory miss, 1 wait cycle on a buffer hit and 2 wait cycles on a register read.
- R7: With `pf_en`=1, a memory miss at address A loads the words at A+1 to A+4. The next four sequential reads hit, and the fifth one misses and refills the buffer.
- R8: A non-sequential memory read refills the buffer from the new address. With `pf_en`=0 every memory read is a miss and the buffer is emptied.
- R9: A new access presented on the edge that ends the acknowledge cycle, with `sel` held high, is accepted. That access's first wait cycle is the drive-high cycle.
- R10: `rdata_oe` is high only in the acknowledge cycle, and `rdata` then carries the requested word.
- R11: A synchronous active-high `rst` returns the port to IDLE, releases the acknowledge and the data bus, and empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Access strobe (chip select) |
| addr | input | AW | Word address; the MSB selects the register space |
| id_in | input | 4 | Target identifier of the access |
| rd_en | input | 1 | Read strobe |
| wr_be | input | BEW | Per-byte write enables |
| burst | input | 1 | Burst flag |
| strap_id | input | 4 | Identifier this port answers to |
| pf_en | input | 1 | Prefetch enable |
| ack_n | output | 1 | Active-low transfer acknowledge value |
| ack_oe | output | 1 | Drive enable of the acknowledge pin |
| rdata | output | DW | Read data value |
| rdata_oe | output | 1 | Drive enable of the data bus |

## Verification
The bench checks how long the acknowledge takes to arrive in each case: sequential hits, the fifth read after a fill (which must miss again), register reads, and reads made with prefetch disabled. A wrong hit rule or a wrong buffer depth shows up as an acknowledge one or several cycles early or late, or as stale data. The bench also presents foreign-identifier cycles, matched write cycles and matched burst cycles between sequential reads. A port that lets a foreign cycle flush the buffer, or lets a matched non-read keep it, gets the next latency wrong. Finally, the bench issues back-to-back reads and checks the drive-high cycle and the release that follows. An acknowledge that sticks low, is never parked high, or stays driven is reported directly at the pins.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } srs_state_t;

    localparam int ID_W = 4;
endpackage

// File: rtl/srs_mem_word.sv
module srs_mem_word #(
    parameter int          AW   = 16,
    parameter int          DW   = 32,
    parameter logic [15:0] SALT = 16'h5A3C
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);
    localparam logic [AW-1:0] SALT_W = AW'(SALT);

    // Computed memory image: upper half is the address, lower half a salted copy.
    always_comb begin
        word = DW'({addr, addr ^ SALT_W});
    end
endmodule

// File: rtl/srs_pf_buf.sv
module srs_pf_buf #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pf_en,
    input  logic          fill,
    input  logic [AW-1:0] fill_addr,
    input  logic          consume,
    input  logic          flush,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] head_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] words   [DEPTH];
    logic [DW-1:0] fetched [DEPTH];
    logic [AW-1:0] tag_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] next_mem(input logic [AW-1:0] a);
        logic [AW-2:0] low;
        low = a[AW-2:0] + 1'b1;
        return {1'b0, low};
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_fetch
        logic [AW-1:0] fa;
        assign fa = {1'b0, fill_addr[AW-2:0] + (AW-1)'(i + 1)};
        srs_mem_word #(.AW(AW), .DW(DW)) u_word (
            .addr (fa),
            .word (fetched[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tag_q <= '0;
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (flush || !pf_en) begin
            cnt_q <= '0;
        end else if (fill) begin
            tag_q <= next_mem(fill_addr);
            cnt_q <= CW'(DEPTH);
            for (int i = 0; i < DEPTH; i++) words[i] <= fetched[i];
        end else if (consume && cnt_q != '0) begin
            tag_q <= next_mem(tag_q);
            cnt_q <= cnt_q - 1'b1;
            for (int i = 0; i < DEPTH - 1; i++) words[i] <= words[i+1];
        end
    end

    assign hit       = pf_en && (cnt_q != '0) && (look_addr == tag_q);
    assign head_data = words[0];

    AST_FILL_LOADS_ALL: assert property (@(posedge clk) disable iff (rst)
        (fill && pf_en && !flush) |=> (cnt_q == CW'(DEPTH))); // R7
    AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (flush || !pf_en) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/sync_rd_slave.sv
module sync_rd_slave
    import srs_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int BEW       = DW / 8,
    parameter int DEPTH     = 4,
    parameter int MISS_WAIT = 4,
    parameter int HIT_WAIT  = 1,
    parameter int REG_WAIT  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  logic [AW-1:0]   addr,
    input  logic [ID_W-1:0] id_in,
    input  logic            rd_en,
    input  logic [BEW-1:0]  wr_be,
    input  logic            burst,
    input  logic [ID_W-1:0] strap_id,
    input  logic            pf_en,
    output logic            ack_n,
    output logic            ack_oe,
    output logic [DW-1:0]   rdata,
    output logic            rdata_oe
);
    localparam int MAX_A    = (MISS_WAIT > REG_WAIT) ? MISS_WAIT : REG_WAIT;
    localparam int MAX_WAIT = (MAX_A > HIT_WAIT) ? MAX_A : HIT_WAIT;
    localparam int WCW      = $clog2(MAX_WAIT + 1);

    srs_state_t     state_q, state_d;
    logic [WCW-1:0] wcnt_q;
    logic [DW-1:0]  data_q;
    logic           park_q;

    logic           cap, id_ok, single, take, is_reg;
    logic           buf_hit, cap_hit, buf_fill, buf_flush;
    logic [DW-1:0]  mem_data, reg_data, head_data, next_data;
    logic [WCW-1:0] wait_sel;

    // Capture decode
    assign cap     = sel && (state_q == ST_IDLE || state_q == ST_ACK);
    assign id_ok   = (id_in == strap_id);
    assign single  = rd_en && (wr_be == '0) && !burst;
    assign take    = cap && id_ok && single;
    assign is_reg  = addr[AW-1];
    assign cap_hit = take && !is_reg && buf_hit;
    assign buf_fill  = take && !is_reg && !buf_hit && pf_en;
    assign buf_flush = (take && is_reg) || (cap && id_ok && !single);

    srs_mem_word #(.AW(AW), .DW(DW)) u_mem (
        .addr (addr),
        .word (mem_data)
    );

    srs_pf_buf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .pf_en     (pf_en),
        .fill      (buf_fill),
        .fill_addr (addr),
        .consume   (cap_hit),
        .flush     (buf_flush),
        .look_addr (addr),
        .hit       (buf_hit),
        .head_data (head_data)
    );

    always_comb begin
        reg_data = '0;
        reg_data[AW-1:0]       = addr;
        reg_data[DW-1 -: ID_W] = strap_id;
        if (is_reg) begin
            next_data = reg_data;
            wait_sel  = WCW'(REG_WAIT);
        end else if (buf_hit) begin
            next_data = head_data;
            wait_sel  = WCW'(HIT_WAIT);
        end else begin
            next_data = mem_data;
            wait_sel  = WCW'(MISS_WAIT);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = take ? ST_WAIT : ST_IDLE;
            ST_WAIT: state_d = (wcnt_q == '0) ? ST_ACK : ST_WAIT;
            ST_ACK:  state_d = take ? ST_WAIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            data_q  <= '0;
            park_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            park_q  <= (state_q == ST_ACK);
            if (take) begin
                data_q <= next_data;
                wcnt_q <= wait_sel - 1'b1;
            end else if (state_q == ST_WAIT && wcnt_q != '0) begin
                wcnt_q <= wcnt_q - 1'b1;
            end
        end
    end

    // Pin outputs
    always_comb begin
        ack_n    = (state_q != ST_ACK);
        ack_oe   = (state_q == ST_ACK) || park_q;
        rdata_oe = (state_q == ST_ACK);
        rdata    = rdata_oe ? data_q : '0;
    end

    AST_ACK_THEN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACK) |=> (ack_oe && ack_n)); // R5
    AST_HIGH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && ack_n) |=> !(ack_oe && ack_n)); // R5
    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && sel && !id_ok) |=> (state_q == ST_IDLE)); // R2
    AST_NONREAD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && sel && id_ok && !single) |=> !rdata_oe); // R3

    if (HIT_WAIT == 1) begin : g_hit_chk
        AST_HIT_ONE_WAIT: assert property (@(posedge clk) disable iff (rst)
            cap_hit |=> (state_q == ST_WAIT) ##1 (state_q == ST_ACK)); // R6
    end
endmodule

// File: tb/test_sync_rd_slave.sv
module test_sync_rd_slave;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] STRAP = 4'h9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic [15:0] addr = '0;
    logic [3:0]  id_in = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic        burst = 1'b0;
    logic        pf_en = 1'b0;
    logic        ack_n, ack_oe, rdata_oe;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the prefetch buffer
    logic [15:0] m_tag = '0;
    int          m_cnt = 0;
    bit          pending = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_rd_slave i_sync_rd_slave (
        .clk(clk), .rst(rst), .sel(sel), .addr(addr), .id_in(id_in),
        .rd_en(rd_en), .wr_be(wr_be), .burst(burst), .strap_id(STRAP),
        .pf_en(pf_en), .ack_n(ack_n), .ack_oe(ack_oe), .rdata(rdata),
        .rdata_oe(rdata_oe)
    );

    function automatic logic [31:0] mem_w(input logic [15:0] a);
        return {a, a ^ 16'h5A3C};
    endfunction

    function automatic logic [31:0] reg_w(input logic [15:0] a);
        return {STRAP, 12'h000, a};
    endfunction

    function automatic logic [15:0] nxt(input logic [15:0] a);
        return {1'b0, a[14:0] + 15'd1};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a negedge. If chained, the previous access is in its ack cycle now.
    task automatic do_read(input logic [15:0] a, input bit pf, input bit chained);
        int          lat;
        int          k;
        bit          early;
        logic [31:0] exp;
        string       req;
        if (!pf) m_cnt = 0;
        if (a[15]) begin
            lat = 2; exp = reg_w(a); m_cnt = 0; req = "R4";
        end else if (pf && m_cnt != 0 && a == m_tag) begin
            lat = 1; exp = mem_w(a); m_tag = nxt(m_tag); m_cnt--; req = "R7";
        end else begin
            lat = 4; exp = mem_w(a); req = "R6";
            if (pf) begin m_tag = nxt(a); m_cnt = 4; end
            else m_cnt = 0;
        end
        sel = 1'b1; addr = a; id_in = STRAP; rd_en = 1'b1; wr_be = '0;
        burst = 1'b0; pf_en = pf;
        step();
        // R1: inputs changed after capture must not matter
        sel = 1'b0; rd_en = 1'b0; addr = a ^ 16'h00F0; id_in = ~STRAP;
        k = 1;
        chk(ack_oe == chained && ack_n, chained ? "R9" : "R5",
            "first wait cycle drive", {ack_oe, ack_n}, {chained, 1'b1});
        early = 0;
        while (!(ack_oe && !ack_n) && k < 12) begin
            if (rdata_oe) early = 1;
            step();
            k++;
        end
        chk(k == lat + 1, req, "ack latency", k, lat + 1);
        chk(!early, "R10", "data driven before ack", early, 0);
        chk(rdata_oe && rdata == exp, "R10", "read data", rdata, exp);
        pending = 1;
    endtask

    task automatic finish_idle();
        if (pending) begin
            step();
            chk(ack_oe && ack_n && !rdata_oe, "R5", "drive-high cycle",
                {ack_oe, ack_n, rdata_oe}, 3'b110);
            step();
            chk(!ack_oe && !rdata_oe, "R5", "release",
                {ack_oe, rdata_oe}, 2'b00);
            pending = 0;
        end
    endtask

    // non-served cycle from idle
    task automatic do_other(input logic [15:0] a, input logic [3:0] id, input logic rd,
                            input logic [3:0] be, input logic bu, input bit pf,
                            input string req);
        bit driven;
        finish_idle();
        if (!pf) m_cnt = 0;
        if (id == STRAP) m_cnt = 0;
        sel = 1'b1; addr = a; id_in = id; rd_en = rd; wr_be = be; burst = bu;
        pf_en = pf;
        step();
        sel = 1'b0; rd_en = 1'b0; wr_be = '0; burst = 1'b0;
        driven = 0;
        for (int i = 0; i < 6; i++) begin
            if (ack_oe || rdata_oe) driven = 1;
            step();
        end
        chk(!driven, req, "ignored cycle drove a pin", driven, 0);
    endtask

    task automatic do_reset();
        finish_idle();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        m_cnt = 0;
        chk(!ack_oe && ack_n && !rdata_oe, "R11", "reset state",
            {ack_oe, ack_n, rdata_oe}, 3'b010);
    endtask

    task automatic seq(input logic [15:0] a, input bit pf);
        finish_idle();
        do_read(a, pf, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        @(negedge clk);
        step();
        rst = 1'b0;
        do_reset(); // R11

        // R6 / R7: miss, four hits, fifth misses
        seq(16'h0100, 1);
        for (int i = 1; i <= 5; i++) seq(16'h0100 + 16'(i), 1);
        // R9: back-to-back
        seq(16'h0200, 1);
        do_read(16'h0201, 1, 1);
        do_read(16'h0202, 1, 1);
        do_read(16'h8007, 1, 1);
        // R4: register read flushed the buffer
        seq(16'h0203, 1);
        seq(16'h8003, 1);
        // R2: foreign cycle leaves buffer intact
        seq(16'h0300, 1);
        do_other(16'h0301, 4'h3, 1'b1, 4'h0, 1'b0, 1, "R2");
        seq(16'h0301, 1);
        // R3: matched write and burst flush
        seq(16'h0400, 1);
        do_other(16'h0401, STRAP, 1'b0, 4'hF, 1'b0, 1, "R3");
        seq(16'h0401, 1);
        do_other(16'h0402, STRAP, 1'b1, 4'h0, 1'b1, 1, "R3");
        seq(16'h0402, 1);
        // R8: non-sequential refill and disabled prefetch
        seq(16'h0500, 1);
        seq(16'h0700, 1);
        seq(16'h0701, 1);
        seq(16'h0501, 1);
        seq(16'h0900, 0);
        seq(16'h0901, 0);
        // R11: reset empties buffer
        seq(16'h0A00, 1);
        do_reset();
        seq(16'h0A01, 1);

        // constrained random
        for (int it = 0; it < 400; it++) begin
            int          r;
            bit          pf;
            bit          ch;
            logic [15:0] a;
            r  = $urandom_range(0, 99);
            pf = ($urandom_range(0, 9) != 0);
            ch = pending && ($urandom_range(0, 1) == 1);
            if (r < 55 && m_cnt != 0) a = m_tag;
            else if (r < 70) a = 16'h8000 | 16'($urandom_range(0, 255));
            else a = 16'($urandom_range(0, 16'h7FF0));
            if (r >= 94) begin
                if (r[0]) do_other(a, STRAP ^ 4'h1, 1'b1, 4'h0, 1'b0, pf, "R2");
                else do_other(a, STRAP, 1'b0, 4'h3, 1'b0, pf, "R3");
            end else if (ch) begin
                do_read(a, pf, 1);
            end else begin
                seq(a, pf);
            end
        end
        finish_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule